// File: doc/BRIEF.md
# Configurable Timer Counter Unit

This block is an up-counter whose width is chosen at run time: it runs either as an 8-bit or as a 16-bit counter. A 3-bit clock-select field chooses what advances it. The choices are a tap of a free-running internal prescaler, or a rising or falling edge on an external pin. The pin is first brought into the system clock domain by a synchronizer. Selecting no source freezes the count.

The counter climbs from zero towards its TOP value. A mode bit sets TOP to either the full-scale value or a programmable compare value. After TOP the counter returns to zero and sets a sticky overflow flag. Software can load the count at any time and clears the flag by writing a one to it.

Top module: `tc_unit`

## Requirements
- R1: After reset, `count` reads 0 and `ovf_flag` reads 0.
- R2: With `clk_sel` = 000 and no load, `count` keeps its value on every clock.
- R3: With `clk_sel` = 001, `count` advances by one on every clock.
- R4: A 10-bit prescaler starts at 0 after reset and increments on every clock. Each `clk_sel` value picks a divide ratio N: 010 gives N = 8, 011 gives 64, 100 gives 256 and 101 gives 1024. With ratio N selected, `count` advances on the clock edge at which the prescaler value modulo N equals N-1.
- R5: `clk_sel` = 110 counts falling edges of `ext_pin` and 111 counts rising edges. A pin level sampled at clock edge e reaches the edge detector two edges later, so `count` advances at edge e+2.
- R6: When `top_cmp` = 0, TOP is full scale: 0x00FF when `wide` = 0 and 0xFFFF when `wide` = 1. A tick at TOP makes `count` 0.
- R7: When `top_cmp` = 1, TOP is `cmp_val`, using only its low byte when `wide` = 0. A tick with `count` equal to TOP wraps to 0. A count already above TOP keeps counting up to full scale and then wraps.
- R8: Every wrap to 0 sets `ovf_flag`, which stays set until it is cleared. A wrap that falls in the same cycle as a clear leaves the flag set.
- R9: A cycle with `ovf_clr` = 1 and no wrap clears `ovf_flag` on the next edge.
- R10: A cycle with `cnt_wr` = 1 loads `cnt_wdata` into the count and replaces any advance due in that cycle.
- R11: While `wide` = 0, `count[15:8]` reads 0. The count wraps at 8 bits, and a load keeps only the low byte of `cnt_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 1 | External count source, asynchronous |
| wide | input | 1 | 1 = 16-bit counting, 0 = 8-bit |
| top_cmp | input | 1 | 1 = TOP is `cmp_val`, 0 = TOP is full scale |
| clk_sel | input | 3 | Count source select (see R2 to R5) |
| cmp_val | input | 16 | Compare value used as TOP |
| cnt_wr | input | 1 | Load strobe for the count |
| cnt_wdata | input | 16 | Load value |
| ovf_clr | input | 1 | Write-one-to-clear strobe for the overflow flag |
| count | output | 16 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Most faults in the counter state show up on `count` at the next clock edge. A wrong prescaler phase is slower to appear. It surfaces only at the first tick of the selected ratio, up to 1024 cycles later, as a tick on the wrong cycle. A fault in the synchronizer delay line shows up as an edge counted one cycle early or late. A wrong TOP decision, or a wrong priority between set and clear, appears on `ovf_flag` one cycle after the wrap.

// File: rtl/tc_unit.sv
module tc_unit #(
  parameter int W     = 16,
  parameter int PRE_W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ext_pin,
  input  logic         wide,
  input  logic         top_cmp,
  input  logic [2:0]   clk_sel,
  input  logic [W-1:0] cmp_val,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         ovf_clr,
  output logic [W-1:0] count,
  output logic         ovf_flag
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] LO_MASK = {{(W-HW){1'b0}}, {HW{1'b1}}};

  logic [PRE_W-1:0] pre_q;
  logic [2:0]       sync_q;
  logic [W-1:0]     cnt_q;
  logic             ovf_q;
  logic             tick, ext_rise, ext_fall, at_end;
  logic [W-1:0]     mask, top, full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pre_q  <= '0;
      sync_q <= '0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      sync_q <= {sync_q[1:0], ext_pin};
    end

  assign ext_rise = sync_q[1] & ~sync_q[2];
  assign ext_fall = ~sync_q[1] & sync_q[2];

  always_comb
    case (clk_sel)
      3'd1:    tick = 1'b1;
      3'd2:    tick = &pre_q[2:0];
      3'd3:    tick = &pre_q[5:0];
      3'd4:    tick = &pre_q[7:0];
      3'd5:    tick = &pre_q[9:0];
      3'd6:    tick = ext_fall;
      3'd7:    tick = ext_rise;
      default: tick = 1'b0;
    endcase

  assign mask   = wide ? '1 : LO_MASK;
  assign full   = mask;
  assign top    = top_cmp ? (cmp_val & mask) : full;
  assign count  = cnt_q & mask;
  assign at_end = (count == top) || (count == full);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (cnt_wr)
        cnt_q <= cnt_wdata & mask;
      else if (tick)
        cnt_q <= at_end ? '0 : (count + 1'b1);
      if (!cnt_wr && tick && at_end)
        ovf_q <= 1'b1;
      else if (ovf_clr)
        ovf_q <= 1'b0;
    end

  assign ovf_flag = ovf_q;
endmodule

// File: rtl/tc_unit_chk.sv
module tc_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   clk_sel,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_wdata,
  input logic         ovf_clr,
  input logic [W-1:0] count,
  input logic         ovf_flag
);
  a_r2_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 3'd0 && !cnt_wr) |=> count[7:0] == $past(count[7:0]));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count[7:0] == $past(cnt_wdata[7:0]));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  a_r8_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> count == '0);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> (!ovf_flag || count == '0));
endmodule

bind tc_unit tc_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cnt_wr(cnt_wr),
  .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag)
);

// File: tb/tc_unit_tb_top.sv
module tc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_pin = 1'b0;
  logic        wide = 1'b0;
  logic        top_cmp = 1'b0;
  logic [2:0]  clk_sel = 3'd0;
  logic [15:0] cmp_val = 16'h0;
  logic        cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = 16'h0;
  logic        ovf_clr = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;

  int n_tests = 0, n_fail = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  tc_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .wide(wide), .top_cmp(top_cmp),
    .clk_sel(clk_sel), .cmp_val(cmp_val), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag)
  );

  // behavioural reference
  int m_cnt, m_pre;
  bit m_ovf, p1, p2, p3;

  function automatic int exp_cnt();
    return wide ? m_cnt : (m_cnt % 256);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_ovf = 0; m_pre = 0; p1 = 0; p2 = 0; p3 = 0;
    end else begin
      int full, top, cur, sel;
      bit tk, wrap;
      sel  = clk_sel;
      full = wide ? 65535 : 255;
      cur  = exp_cnt();
      top  = top_cmp ? (wide ? int'(cmp_val) : int'(cmp_val) % 256) : full;
      case (sel)
        1: tk = 1;
        2: tk = (m_pre % 8) == 7;
        3: tk = (m_pre % 64) == 63;
        4: tk = (m_pre % 256) == 255;
        5: tk = (m_pre % 1024) == 1023;
        6: tk = !p2 && p3;
        7: tk = p2 && !p3;
        default: tk = 0;
      endcase
      wrap = 0;
      if (cnt_wr) m_cnt = wide ? int'(cnt_wdata) : int'(cnt_wdata) % 256;
      else if (tk) begin
        if (cur == top || cur == full) begin m_cnt = 0; wrap = 1; end
        else m_cnt = cur + 1;
      end
      if (wrap) m_ovf = 1;
      else if (ovf_clr) m_ovf = 0;
      m_pre = (m_pre + 1) % 1024;
      p3 = p2; p2 = p1; p1 = ext_pin;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!done) begin
      chk({phase, " count"}, count, exp_cnt());
      chk({phase, " ovf"}, ovf_flag, m_ovf);
    end
    if (cyc > 150000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [15:0] v);
    cnt_wr = 1; cnt_wdata = v;
    @(negedge clk);
    cnt_wr = 0;
  endtask

  task automatic clr_ovf();
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
  endtask

  initial begin
    step(3);
    chk("R1 reset count", count, 0);
    chk("R1 reset ovf", ovf_flag, 0);
    rst_n = 1;
    step(2);
    phase = "R3";
    clk_sel = 3'd1;
    step(1);
    chk("R3 one step", count, 1);
    step(300);
    chk("R6 R8 8-bit wrap flag", ovf_flag, 1);
    phase = "R9"; clr_ovf();
    chk("R9 cleared", ovf_flag, 0);
    phase = "R2"; clk_sel = 3'd0;
    load(16'h0042);
    step(20);
    chk("R2 held", count, 16'h42);
    phase = "R10"; clk_sel = 3'd1;
    load(16'h1234);
    chk("R10 R11 load beats tick, low byte", count, 16'h34);
    phase = "R6"; clk_sel = 3'd0; wide = 1;
    load(16'hFFFE);
    clk_sel = 3'd1;
    step(1);
    chk("R6 16-bit at max", count, 16'hFFFF);
    step(1);
    clk_sel = 3'd0;
    chk("R6 16-bit wrap", count, 0);
    chk("R8 set on 16-bit wrap", ovf_flag, 1);
    phase = "R8"; load(16'hFFFF);
    clk_sel = 3'd1; ovf_clr = 1;
    step(1);
    ovf_clr = 0; clk_sel = 3'd0;
    chk("R8 set beats clear", ovf_flag, 1);
    clr_ovf();
    phase = "R7"; top_cmp = 1; cmp_val = 16'h000F;
    load(16'h000E);
    clk_sel = 3'd1;
    step(2);
    clk_sel = 3'd0;
    chk("R7 wrap at compare", count, 0);
    chk("R7 flag", ovf_flag, 1);
    clr_ovf();
    wide = 0; cmp_val = 16'h0105;
    clk_sel = 3'd1;
    step(40);
    phase = "R7"; clk_sel = 3'd0; cmp_val = 16'h0020;
    load(16'h0030);
    clk_sel = 3'd1;
    step(1);
    clk_sel = 3'd0;
    chk("R7 above top keeps counting", count, 16'h31);
    clk_sel = 3'd1; step(300); clr_ovf();
    phase = "R11"; wide = 1; top_cmp = 0; load(16'hAB00); wide = 0;
    step(1);
    chk("R11 upper byte zero", count[15:8], 0);
    phase = "R4";
    for (int s = 2; s <= 5; s++) begin
      clk_sel = 3'(s);
      step(2100);
    end
    phase = "R5"; clk_sel = 3'd7; wide = 1;
    for (int i = 0; i < 40; i++) begin
      ext_pin = ~ext_pin;
      step(3 + (i % 4));
    end
    clk_sel = 3'd6;
    for (int i = 0; i < 40; i++) begin
      ext_pin = ~ext_pin;
      step(2 + (i % 5));
    end
    clk_sel = 3'd0; load(16'h0);
    ext_pin = 0; step(4);
    clk_sel = 3'd7; ext_pin = 1;
    step(2);
    chk("R5 rise not yet counted", count, 0);
    step(1);
    chk("R5 rise counted at e+2", count, 1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule